// File: doc/BRIEF.md
# Beat-Paced Melody Sequencer with Keyboard Override

This block produces the 8-bit note-select word for a downstream tone decoder. Bit i of the word, when high, selects scale note i+1, and an all-zero word means silence. A mode input picks one of two sources. In stored mode, a fixed 32-step melody is played. A step counter indexes the melody, and that counter advances once per beat. In keyboard mode, the 8-bit keyboard word goes straight to the output.

The beat is a one-cycle clock enable. It comes from a terminal-count divider that runs on the system clock. At 32 MHz, the default ratio of 8,000,000 gives four beats per second, so each step lasts 0.25 s. No derived clock is used. The divide ratio is a parameter, so a bench can use a short beat. While keyboard mode is selected, the melody position is frozen. When stored mode returns, playback continues from the same step.

Top module: `melody_seq`

## Requirements
- R1: `noteOut` is 8 bits. In stored mode it is either all zero or has exactly one bit set, and bit i selects scale note i+1 (for example, 8'b0000_0010 selects note 2).
- R2: With `modeKey`=0 the output is the stored melody entry at the current step. With `modeKey`=1 the output equals `keyIn` in the same cycle, with no register delay.
- R3: The beat enable is high for exactly one cycle out of every `TICK_DIV` clock cycles (default 8,000,000, which is 4 Hz at 32 MHz).
- R4: In stored mode, each beat advances the step by one, and the output then shows the next melody entry.
- R5: The melody has 32 steps. After step 31 the next beat returns to step 0.
- R6: A melody entry of zero is a rest, and during that step the output is 8'h00.
- R7: A synchronous reset clears the step counter and the beat divider. After reset the output shows step 0, and the first advance comes `TICK_DIV` cycles after reset is released.
- R8: While `modeKey`=1 the step counter holds. When stored mode returns, the output at once shows the entry of the step that was held.
- R9: In keyboard mode, any `keyIn` pattern is passed through unchanged, including all-zero and multi-bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| modeKey | input | 1 | 0 selects the stored melody, 1 selects keyboard pass-through |
| keyIn | input | 8 | Keyboard note word |
| noteOut | output | 8 | Selected note word (one-hot, or zero for a rest) |

## Verification
The melody path is run for more than one full pass with a short beat. Each step is compared with an independent copy of the table, which separates a correct step order from a wrong stride, an early or late wrap, and a table entry that has been changed; the rest steps show that zero entries come out silent. The keyboard path is driven with single-bit, multi-bit, all-zero and all-one words, which shows that the input is passed through as it is and not filtered to one-hot. The mode switch is also applied in the middle of the melody, which shows that the step is held and then resumed. A reset in the middle of a run, followed by a check of the first beat's timing, shows that both the step counter and the divider are cleared.

// File: rtl/melody_pkg.sv
package melody_pkg;

  localparam int NOTE_W = 8;

  // Strobes from the beat control to the note datapath
  typedef struct packed {
    logic beatTick;  // one-cycle beat enable
    logic stepAdv;   // advance the melody step on this cycle
  } beat_strobe_t;

  // Stored melody: n -> bit (n-1) set, 0 -> rest
  function automatic logic [NOTE_W-1:0] melodyNote(input int idx);
    logic [NOTE_W-1:0] n;
    case (idx % 32)
      0, 3, 4, 7, 21, 24, 26: n = 8'h01;
      1, 5:                   n = 8'h02;
      2, 6, 8, 12, 20:        n = 8'h04;
      9, 13, 19:              n = 8'h08;
      10, 14, 16, 18, 25:     n = 8'h10;
      17, 30:                 n = 8'h20;
      29:                     n = 8'h40;
      28:                     n = 8'h80;
      default:                n = 8'h00;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import melody_pkg::*;
#(
  parameter int TICK_DIV = 8_000_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         modeKey,
  output beat_strobe_t strobe
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             atLast;

  assign atLast = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst)         divCnt <= '0;
    else if (atLast) divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobe.beatTick = atLast;
    strobe.stepAdv  = atLast & ~modeKey;
  end
endmodule

// File: rtl/note_path.sv
module note_path
  import melody_pkg::*;
#(
  parameter int STEPS  = 32,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  beat_strobe_t      strobe,
  input  logic              modeKey,
  input  logic [NOTE_W-1:0] keyIn,
  output logic [NOTE_W-1:0] noteOut,
  output logic [STEP_W-1:0] stepIdx
);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  logic [NOTE_W-1:0] romArr [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_rom
    assign romArr[i] = melodyNote(i);
  end

  always_ff @(posedge clk) begin
    if (rst)                 stepIdx <= '0;
    else if (strobe.stepAdv) stepIdx <= (stepIdx == STEP_LAST) ? '0 : stepIdx + 1'b1;
  end

  assign noteOut = modeKey ? keyIn : romArr[stepIdx];
endmodule

// File: rtl/melody_seq.sv
module melody_seq
  import melody_pkg::*;
#(
  parameter int TICK_DIV = 8_000_000,
  parameter int STEPS    = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        modeKey,
  input  logic [7:0]  keyIn,
  output logic [7:0]  noteOut
);
  localparam int STEP_W = $clog2(STEPS);

  beat_strobe_t      strobe;
  logic [STEP_W-1:0] stepIdx;
  logic              beatTick;
  logic              stepAdv;

  assign beatTick = strobe.beatTick;
  assign stepAdv  = strobe.stepAdv;

  beat_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .modeKey (modeKey),
    .strobe  (strobe)
  );

  note_path #(.STEPS(STEPS), .STEP_W(STEP_W)) u_path (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .modeKey (modeKey),
    .keyIn   (keyIn),
    .noteOut (noteOut),
    .stepIdx (stepIdx)
  );
endmodule

// File: rtl/melody_seq_chk.sv
module melody_seq_chk #(
  parameter int TICK_DIV = 8_000_000,
  parameter int STEPS    = 32,
  parameter int STEP_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              modeKey,
  input logic [7:0]        keyIn,
  input logic [7:0]        noteOut,
  input logic [STEP_W-1:0] stepIdx,
  input logic              beatTick,
  input logic              stepAdv
);
  int unsigned sinceTick;

  always_ff @(posedge clk) begin
    if (rst || beatTick) sinceTick <= 0;
    else                 sinceTick <= sinceTick + 1;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    !modeKey |-> $onehot0(noteOut));

  a_r2_key_pass: assert property (@(posedge clk) disable iff (rst)
    modeKey |-> noteOut == keyIn);

  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    beatTick |-> sinceTick == TICK_DIV - 1);

  a_r3_no_late_tick: assert property (@(posedge clk) disable iff (rst)
    !beatTick |-> sinceTick < TICK_DIV - 1);

  a_r4_advance: assert property (@(posedge clk) disable iff (rst)
    (stepAdv && stepIdx != STEP_W'(STEPS - 1)) |=> stepIdx == $past(stepIdx) + 1'b1);

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (stepAdv && stepIdx == STEP_W'(STEPS - 1)) |=> stepIdx == '0);

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> stepIdx == '0);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    modeKey |=> $stable(stepIdx));
endmodule

bind melody_seq melody_seq_chk #(.TICK_DIV(TICK_DIV), .STEPS(STEPS), .STEP_W(STEP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .modeKey  (modeKey),
  .keyIn    (keyIn),
  .noteOut  (noteOut),
  .stepIdx  (stepIdx),
  .beatTick (beatTick),
  .stepAdv  (stepAdv)
);

// File: tb/melody_seq_tb.sv
module melody_seq_tb;
  localparam int TICK = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeKey = 1'b0;
  logic [7:0] keyIn = 8'h00;
  logic [7:0] noteOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [7:0] REF_TUNE [32] = '{
    8'h01, 8'h02, 8'h04, 8'h01, 8'h01, 8'h02, 8'h04, 8'h01,
    8'h04, 8'h08, 8'h10, 8'h00, 8'h04, 8'h08, 8'h10, 8'h00,
    8'h10, 8'h20, 8'h10, 8'h08, 8'h04, 8'h01, 8'h00, 8'h00,
    8'h01, 8'h10, 8'h01, 8'h00, 8'h80, 8'h40, 8'h20, 8'h00
  };

  // keyboard stimulus vectors: input word, expected output
  localparam logic [15:0] KEY_VEC [6] = '{
    {8'h02, 8'h02}, {8'h80, 8'h80}, {8'h00, 8'h00},
    {8'h05, 8'h05}, {8'hFF, 8'hFF}, {8'h41, 8'h41}
  };

  always #4 clk = ~clk;

  melody_seq #(.TICK_DIV(TICK)) u_dut (
    .clk(clk), .rst(rst), .modeKey(modeKey), .keyIn(keyIn), .noteOut(noteOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int step;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 check("R7 reset step0", noteOut, REF_TUNE[0]);

    // R4/R5/R6/R1: walk more than one full pass of the melody
    step = 0;
    for (int k = 1; k <= 40; k++) begin
      repeat (TICK) @(posedge clk);
      @(negedge clk);
      step = k % 32;
      if (REF_TUNE[step] == 8'h00) check("R6 rest", noteOut, 8'h00);
      else if (step == 0)          check("R5 wrap", noteOut, REF_TUNE[step]);
      else                         check("R4 step order", noteOut, REF_TUNE[step]);
      if ($countones(noteOut) > 1) check("R1 onehot", noteOut, REF_TUNE[step]);
    end

    // R2/R9: keyboard override, vector table
    modeKey = 1'b1;
    for (int v = 0; v < 6; v++) begin
      keyIn = KEY_VEC[v][15:8];
      #1 check("R9 key passthrough", noteOut, KEY_VEC[v][7:0]);
      @(negedge clk);
    end
    keyIn = 8'h10;
    repeat (3 * TICK + 1) @(negedge clk);
    #1 check("R2 key mode", noteOut, 8'h10);

    // R8: return to stored mode resumes at held step
    modeKey = 1'b0;
    #1 check("R8 resume held step", noteOut, REF_TUNE[step]);
    check("R2 stored mode", noteOut, REF_TUNE[8]);

    // R7: reset mid run, then first beat timing
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1 check("R7 after reset", noteOut, REF_TUNE[0]);
    repeat (TICK - 1) @(posedge clk);
    @(negedge clk);
    check("R3 no early beat", noteOut, REF_TUNE[0]);
    @(posedge clk);
    @(negedge clk);
    check("R3 beat at TICK_DIV", noteOut, REF_TUNE[1]);

    finish_run();
  end
endmodule